// File: doc/BRIEF.md
# Two-Wire Register Port with 16-bit Words

This block is the serial control port of an audio device. It listens on a two-wire bus (SCL clock, SDA data) running at up to fast-mode speed, answers one seven-bit device address, and gives a bus master access to a bank of sixteen-bit registers. Each register moves over the bus as a byte pair, high byte first, and the pair is preceded by a one-byte register index. Both bus lines are first brought into the system clock domain through two flip-flops. The block then detects START and STOP conditions and runs a bit-level state machine that samples SDA on rising SCL and changes its own SDA drive on falling SCL.

The upper five bits of the device address are a parameter. The two lowest bits come from a pair of strap pins, so four devices can share one bus. Indices 0x00 to 0x2E are read/write control words, and their contents are presented on a flat output vector for the rest of the chip. Index 0x2F is a read-only status word that carries an eight-bit temperature input. Every index above that reads as zero and ignores writes. For open-drain pads the block has a single output that, when high, pulls SDA low.

Top module: `i2c_word_slave`

## Requirements
- R1: The device address is the upper five bits of parameter DEV_BASE (default 7'h34) followed by strap[1:0]. Only a matching address byte is acknowledged. With any other address the block releases SDA and ignores the bus until the next START.
- R2: START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) are detected on the synchronized lines. A START seen in any phase, including a repeated START, restarts the address phase and keeps the current register index.
- R3: In a write transfer the address byte (R/W bit 0) is followed by one index byte and then data bytes, high byte first. Every byte is acknowledged, and a register is updated only once the second byte of a pair has been received.
- R4: A STOP that comes after only the first byte of a pair discards that byte, and the register keeps its old value.
- R5: In a read transfer (repeated START, address byte with R/W bit 1) the block sends the high byte MSB first, waits for the master's acknowledge, and then sends the low byte. After the low byte it releases SDA and ends the word whether the master acknowledges or not. A not-acknowledge after the high byte also ends the read.
- R6: After each completed write pair the register index increments, so consecutive pairs in one write transfer land in consecutive registers.
- R7: Index 0x2F is read-only. It reads as {8'h00, temp_in}. Writes to it are acknowledged and have no effect.
- R8: Indices 0x30 and above read as 16'h0000, and writes to them are acknowledged and ignored.
- R9: After reset all control registers read 16'h0000 and SDA is released.
- R10: The SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap | input | 2 | Low two bits of the device address |
| temp_in | input | 8 | Temperature reported in the status word |
| sda_pull_low | output | 1 | High pulls SDA low (open-drain enable) |
| cfg_flat | output | 752 | Control registers 0x00..0x2E, register n at bits [16n+15:16n] |

## Verification
The hardest case to reach from the ports is a bus event that arrives mid-word. Examples are a STOP after the high data byte, a master acknowledge on the final read byte that must not leave SDA held, and a transfer that begins with a foreign address and then carries bytes that look like valid register data. The stimulus reaches these states with a bus-master model that builds transfers byte by byte, so it can stop early, acknowledge where a normal master would not, or change the strap value between transfers. Every effect is then read back over the bus.

// File: rtl/i2cr_pkg.sv
// Shared types for the two-wire register port.
// Assumes: nothing beyond the enum encoding chosen here.
package i2cr_pkg;
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_DEV,
        PH_DEV_ACK,
        PH_SUB,
        PH_SUB_ACK,
        PH_WR,
        PH_WR_ACK,
        PH_RD,
        PH_RD_ACK
    } phase_t;
endpackage

// File: rtl/i2cr_line_sync.sv
// Brings SCL and SDA into the clk domain through two flops and derives
// single-cycle SCL edge, START and STOP pulses from the synchronized lines.
// Assumes: each SCL level lasts several clk cycles; idle bus is high.
module i2cr_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_m, scl_s, scl_q;
    logic sda_m, sda_q;

    // Two-stage synchronizer plus one history stage per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {scl_q, scl_s, scl_m} <= 3'b111;
            {sda_q, sda_s, sda_m} <= 3'b111;
        end else begin
            {scl_q, scl_s, scl_m} <= {scl_s, scl_m, scl_in};
            {sda_q, sda_s, sda_m} <= {sda_s, sda_m, sda_in};
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cr_link_fsm.sv
// Bit and byte sequencer: matches the device address, takes the register
// index, assembles big-endian write pairs and serializes read words.
// Assumes: edge pulses from i2cr_line_sync; read data is combinational.
module i2cr_link_fsm
    import i2cr_pkg::*;
#(
    parameter logic [6:0] DEV_BASE = 7'h34,
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              sda_low,
    output phase_t            phase
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    logic [6:0]        dev_addr;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg, hi_byte, tx;
    logic              second, rw, mack;

    assign dev_addr = {DEV_BASE[6:2], strap};

    // Protocol sequencer: sample on SCL rise, drive on SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            hi_byte <= '0;
            tx      <= '0;
            second  <= 1'b0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            ptr     <= '0;
            sda_low <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                phase   <= PH_DEV;
                bit_cnt <= '0;
                second  <= 1'b0;
                sda_low <= 1'b0;
            end else if (stop_det) begin
                phase   <= PH_IDLE;
                second  <= 1'b0;
                sda_low <= 1'b0;
            end else if (phase == PH_DEV || phase == PH_SUB || phase == PH_WR) begin
                if (scl_rise) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (scl_fall && bit_cnt == LAST) begin
                    bit_cnt <= '0;
                    if (phase == PH_DEV) begin
                        if (shreg[7:1] == dev_addr) begin
                            rw      <= shreg[0];
                            sda_low <= 1'b1;
                            phase   <= PH_DEV_ACK;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end else if (phase == PH_SUB) begin
                        ptr     <= shreg;
                        sda_low <= 1'b1;
                        phase   <= PH_SUB_ACK;
                    end else begin
                        sda_low <= 1'b1;
                        phase   <= PH_WR_ACK;
                        second  <= ~second;
                        if (!second) begin
                            hi_byte <= shreg;
                        end else begin
                            wr_en   <= 1'b1;
                            wr_addr <= ptr;
                            wr_data <= {hi_byte, shreg};
                            ptr     <= ptr + 1'b1;
                        end
                    end
                end
            end else if (phase == PH_DEV_ACK) begin
                if (scl_fall) begin
                    second <= 1'b0;
                    if (rw) begin
                        phase   <= PH_RD;
                        sda_low <= ~rd_data[DATA_W-1];
                        tx      <= {rd_data[DATA_W-2:BYTE_W], 1'b0};
                        bit_cnt <= CNT_W'(1);
                    end else begin
                        phase   <= PH_SUB;
                        sda_low <= 1'b0;
                    end
                end
            end else if (phase == PH_SUB_ACK || phase == PH_WR_ACK) begin
                if (scl_fall) begin
                    sda_low <= 1'b0;
                    phase   <= PH_WR;
                end
            end else if (phase == PH_RD) begin
                if (scl_fall) begin
                    if (bit_cnt == LAST) begin
                        sda_low <= 1'b0;
                        bit_cnt <= '0;
                        phase   <= PH_RD_ACK;
                    end else begin
                        sda_low <= ~tx[BYTE_W-1];
                        tx      <= {tx[BYTE_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end else if (phase == PH_RD_ACK) begin
                if (scl_rise) begin
                    mack <= ~sda_s;
                end else if (scl_fall) begin
                    if (mack && !second) begin
                        second  <= 1'b1;
                        phase   <= PH_RD;
                        sda_low <= ~rd_data[BYTE_W-1];
                        tx      <= {rd_data[BYTE_W-2:0], 1'b0};
                        bit_cnt <= CNT_W'(1);
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2cr_reg_store.sv
// Register bank: read/write control words below RO_IDX, a read-only
// temperature word at RO_IDX, and zero for every higher index.
// Assumes: one write strobe per completed pair from the sequencer.
module i2cr_reg_store #(
    parameter int REG_COUNT = 48,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int TEMP_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [TEMP_W-1:0]             temp_in,
    output logic [DATA_W-1:0]             rd_data,
    output logic [(REG_COUNT-1)*DATA_W-1:0] cfg_flat
);
    localparam int RO_IDX = REG_COUNT - 1;

    logic [DATA_W-1:0] regs [RO_IDX];

    for (genvar g = 0; g < RO_IDX; g++) begin : g_word
        // One control word: cleared by reset, loaded by a matching strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
                regs[g] <= wr_data;
        end
        assign cfg_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    // Read mux over control words, status word and reserved space.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(RO_IDX)) begin
            rd_data = {{(DATA_W-TEMP_W){1'b0}}, temp_in};
        end else begin
            for (int i = 0; i < RO_IDX; i++)
                if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
        end
    end
endmodule

// File: rtl/i2c_word_slave.sv
// Top of the two-wire register port: synchronizer, sequencer, register bank.
// Assumes: clk runs at least 16x SCL; pads are open-drain outside the block.
module i2c_word_slave #(
    parameter logic [6:0] DEV_BASE  = 7'h34,
    parameter int         REG_COUNT = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_in,
    input  logic                     sda_in,
    input  logic [1:0]               strap,
    input  logic [7:0]               temp_in,
    output logic                     sda_pull_low,
    output logic [(REG_COUNT-1)*16-1:0] cfg_flat
);
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det, wr_en;
    logic [ADDR_W-1:0] wr_addr, ptr;
    logic [DATA_W-1:0] wr_data, rd_data;
    i2cr_pkg::phase_t  link_phase;

    i2cr_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cr_link_fsm #(.DEV_BASE(DEV_BASE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .strap(strap), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_data(rd_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ptr(ptr),
        .sda_low(sda_pull_low), .phase(link_phase)
    );

    i2cr_reg_store #(.REG_COUNT(REG_COUNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TEMP_W(8)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(ptr), .temp_in(temp_in),
        .rd_data(rd_data), .cfg_flat(cfg_flat)
    );
endmodule

// File: rtl/i2cr_checker.sv
// Protocol checks for i2c_word_slave, attached by bind.
// Assumes: SCL low time is longer than the synchronizer latency.
module i2cr_checker
    import i2cr_pkg::*;
#(
    parameter int CFG_W = 752
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_pull_low,
    input  logic             start_det,
    input  logic             wr_en,
    input  phase_t           link_phase,
    input  logic [CFG_W-1:0] cfg_flat
);
    // R10: own SDA drive only moves while the bus clock is low.
    p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_low) |-> !scl_in);

    // R9: SDA released on leaving reset.
    p_reset_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sda_pull_low);

    // R3: control words change only right after a completed-pair strobe.
    p_cfg_after_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_flat) |-> $past(wr_en));

    // R3: a commit strobe lasts exactly one cycle.
    p_single_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R2: any START returns the sequencer to the address phase.
    p_start_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> link_phase == PH_DEV);
endmodule

bind i2c_word_slave i2cr_checker #(.CFG_W((REG_COUNT-1)*16)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull_low(sda_pull_low),
    .start_det(start_det), .wr_en(wr_en), .link_phase(link_phase),
    .cfg_flat(cfg_flat)
);

// File: tb/sim_i2c_word_slave.sv
module sim_i2c_word_slave;
    localparam int HALF = 20;
    localparam int NVEC = 6;
    // Each entry: {index[7:0], write data[15:0], expected readback[15:0]}
    localparam logic [39:0] VEC [NVEC] = '{
        {8'h00, 16'hA55A, 16'hA55A},
        {8'h2E, 16'h1234, 16'h1234},
        {8'h2F, 16'hFFFF, 16'h005C},
        {8'h30, 16'hBEEF, 16'h0000},
        {8'h45, 16'hCAFE, 16'h0000},
        {8'h10, 16'h0001, 16'h0001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [1:0] strap = 2'b01;
    logic [7:0] temp = 8'h5C;
    logic sda_pull_low;
    logic [47*16-1:0] cfg_flat;
    logic sda_bus;
    logic [6:0] dev_id;
    int nchk = 0, nfail = 0;

    assign sda_bus = m_sda & ~sda_pull_low;

    always #2 clk = ~clk;

    i2c_word_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .strap(strap), .temp_in(temp), .sda_pull_low(sda_pull_low),
        .cfg_flat(cfg_flat)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string what, input logic [15:0] got, input logic [15:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold(4);
        m_scl = 1'b1; hold(HALF);
        m_sda = 1'b0; hold(HALF);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold(4);
        m_scl = 1'b1; hold(HALF);
        m_sda = 1'b1; hold(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hold(HALF);
            m_scl = 1'b1; hold(HALF);
            m_scl = 1'b0;
        end
        m_sda = 1'b1; hold(HALF);
        m_scl = 1'b1; hold(HALF/2);
        ack = ~sda_bus; hold(HALF/2);
        m_scl = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(HALF);
            m_scl = 1'b1; hold(HALF/2);
            d[i] = sda_bus; hold(HALF/2);
            m_scl = 1'b0;
        end
        m_sda = ~give_ack; hold(HALF);
        m_scl = 1'b1; hold(HALF);
        m_scl = 1'b0;
        m_sda = 1'b1;
    endtask

    task automatic write_word(input logic [7:0] ra, input logic [15:0] d, output logic [3:0] acks);
        bus_start();
        send_byte({dev_id, 1'b0}, acks[3]);
        send_byte(ra, acks[2]);
        send_byte(d[15:8], acks[1]);
        send_byte(d[7:0], acks[0]);
        bus_stop();
    endtask

    task automatic read_word(input logic [7:0] ra, input logic last_ack, output logic [15:0] d);
        logic a;
        bus_start();
        send_byte({dev_id, 1'b0}, a);
        send_byte(ra, a);
        bus_start();
        send_byte({dev_id, 1'b1}, a);
        recv_byte(1'b1, d[15:8]);
        recv_byte(last_ack, d[7:0]);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] rd;
        logic [3:0]  acks;
        logic        a;
        dev_id = {5'b01101, strap};
        hold(5);
        rst_n = 1'b1;
        hold(5);

        // R9: released SDA and cleared registers after reset
        check("R9 sda released", {15'd0, sda_pull_low}, 16'h0000);
        read_word(8'h05, 1'b0, rd);
        check("R9 reset value", rd, 16'h0000);

        // Vector table: R3 R5 R7 R8 write then read back
        for (int v = 0; v < NVEC; v++) begin
            write_word(VEC[v][39:32], VEC[v][31:16], acks);
            check("R3 write acks", {12'd0, acks}, 16'h000F);
            read_word(VEC[v][39:32], 1'b0, rd);
            check("R5/R7/R8 readback", rd, VEC[v][15:0]);
        end

        // R1: foreign address not acknowledged, following bytes ignored
        bus_start();
        send_byte({7'h36, 1'b0}, a);
        check("R1 foreign nack", {15'd0, a}, 16'h0000);
        send_byte(8'h00, a);
        send_byte(8'hFF, a);
        send_byte(8'hFF, a);
        bus_stop();
        read_word(8'h00, 1'b0, rd);
        check("R1 foreign ignored", rd, 16'hA55A);

        // R4: STOP after first byte of a pair discards it
        bus_start();
        send_byte({dev_id, 1'b0}, a);
        send_byte(8'h10, a);
        send_byte(8'h77, a);
        bus_stop();
        read_word(8'h10, 1'b0, rd);
        check("R4 partial discarded", rd, 16'h0001);

        // R2: repeated START after one data byte restarts cleanly
        bus_start();
        send_byte({dev_id, 1'b0}, a);
        send_byte(8'h12, a);
        send_byte(8'h99, a);
        write_word(8'h12, 16'h4321, acks);
        read_word(8'h12, 1'b0, rd);
        check("R2 restart mid-pair", rd, 16'h4321);

        // R6: two pairs in one write land in consecutive registers
        bus_start();
        send_byte({dev_id, 1'b0}, a);
        send_byte(8'h08, a);
        send_byte(8'h11, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h22, a);
        bus_stop();
        read_word(8'h08, 1'b0, rd);
        check("R6 first word", rd, 16'h1111);
        read_word(8'h09, 1'b0, rd);
        check("R6 second word", rd, 16'h2222);

        // R5: master ACK on the low byte, then STOP; bus must stay usable
        read_word(8'h08, 1'b1, rd);
        check("R5 ack ending data", rd, 16'h1111);
        check("R5 sda released", {15'd0, sda_bus}, 16'h0001);
        read_word(8'h09, 1'b0, rd);
        check("R5 next transfer", rd, 16'h2222);

        // R7: status word follows the temperature input
        temp = 8'hA7;
        read_word(8'h2F, 1'b0, rd);
        check("R7 temperature", rd, 16'h00A7);

        // R1: strap change moves the device address
        strap = 2'b11;
        bus_start();
        send_byte({7'h35, 1'b0}, a);
        bus_stop();
        check("R1 old address nack", {15'd0, a}, 16'h0000);
        dev_id = {5'b01101, strap};
        write_word(8'h01, 16'h0F0F, acks);
        check("R1 new address acks", {12'd0, acks}, 16'h000F);
        read_word(8'h01, 1'b0, rd);
        check("R1 new address data", rd, 16'h0F0F);

        summary();
    end
endmodule